// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block computes one 32-bit saturating arithmetic operation per cycle, picked by a 4-bit opcode. It covers signed and unsigned add and subtract, signed doubling, and clamping to a bit position chosen at run time. The clamp comes in a signed and an unsigned flavour, and each flavour has a whole-word form and a form that works on two 16-bit lanes. The result is combinational from the inputs. Whenever an operation has to clamp its result, that is a saturation event.

A saturation event in a cycle where `valid_i` is high sets a sticky flag on the next clock edge. The flag is a two-state machine. Its states are FLAG_CLEAR and FLAG_SET. The transitions are:

- SET_ON_EVENT: FLAG_CLEAR to FLAG_SET, when `valid_i` is high, a saturation event occurs and `clear_i` is low.
- CLEAR_CMD: any state to FLAG_CLEAR, when `clear_i` is high.
- HOLD: the state is kept in every other cycle.

Only `clear_i` or reset can return the flag to zero.

Top module: `satalu_top`

## Requirements
- R1: Signed add (opcode 0) returns a+b unless the true sum leaves the signed 32-bit range; then it returns 0x7FFFFFFF when `a_i` is non-negative and 0x80000000 otherwise, and that is a saturation event.
- R2: Signed subtract (opcode 1) returns a-b unless the true difference leaves the signed 32-bit range; then it returns 0x7FFFFFFF when `a_i` is non-negative and 0x80000000 otherwise, as an event.
- R3: Unsigned add (opcode 2) returns 0xFFFFFFFF when the sum exceeds 32 bits, and unsigned subtract (opcode 3) returns 0 when `b_i` is greater than `a_i`. Both cases are events.
- R4: Signed doubling (opcode 4) of `a_i` returns 0x7FFFFFFF for signed values of 0x40000000 or more and 0x80000000 for signed values of 0xC0000000 or less, with an event in both cases (exactly 0xC0000000 included). All other values return `a_i` shifted left by one.
- R5: Signed clamp (opcode 5) at s=`pos_i` returns 2^s-1 when signed `a_i` exceeds it and -2^s when signed `a_i` is below it, each as an event. Otherwise it returns `a_i`. Positions 0 and 31 are included.
- R6: Unsigned clamp (opcode 6) at s=`pos_i` returns 0 for negative signed `a_i` and 2^s-1 for signed `a_i` above it, each as an event. Otherwise it returns `a_i`.
- R7: The lane forms (opcode 7 signed, opcode 8 unsigned) take bits 15:0 and bits 31:16 of `a_i` as two sign-extended values. Each lane is clamped independently under the rules of R5 and R6, and each lane result is truncated to 16 bits: the low lane goes to bits 15:0 and the high lane to bits 31:16. An event in either lane counts.
- R8: `sticky_o` rises on the edge after a cycle with `valid_i` high, a saturation event and `clear_i` low. No operation ever clears it.
- R9: `clear_i` high makes `sticky_o` zero on the next edge, even when a saturation event with `valid_i` falls in the same cycle.
- R10: While `valid_i` is low, `sticky_o` keeps its value whatever the operands do.
- R11: After reset, `sticky_o` is zero.
- R12: Opcodes 9 to 15 return 0 and cause no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Qualifies the operation for flag update |
| clear_i | input | 1 | Synchronous clear of the sticky flag |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Clamp bit position |
| result_o | output | 32 | Saturated result |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
The flag clear and a flag set can fall in the same cycle. To provoke this, the bench drives `clear_i` high together with `valid_i` and an operand pair that saturates, such as a signed add of 0x7FFFFFFF and 1. On the following edge the flag must be zero, because clear wins over set. The reference model applies the same priority on every clock and checks each cycle's result and flag, so random stimulus with occasional clears covers this overlap many more times.

// File: rtl/satalu_pkg.sv
package satalu_pkg;
    typedef enum logic [3:0] {
        OP_SADD   = 4'd0,
        OP_SSUB   = 4'd1,
        OP_UADD   = 4'd2,
        OP_USUB   = 4'd3,
        OP_SDBL   = 4'd4,
        OP_SCLAMP = 4'd5,
        OP_UCLAMP = 4'd6,
        OP_SLANE  = 4'd7,
        OP_ULANE  = 4'd8
    } sat_op_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import satalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  sat_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o,
    output logic          sat_o
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] QPOS = {2'b01, {(DW-2){1'b0}}};
    localparam logic [DW-1:0] QNEG = {2'b11, {(DW-2){1'b0}}};

    logic [DW:0]   sum_w;
    logic [DW:0]   dif_w;
    logic [DW-1:0] lim_w;
    logic          sovf_add;
    logic          sovf_sub;

    assign sum_w    = {1'b0, a_i} + {1'b0, b_i};
    assign dif_w    = {1'b0, a_i} - {1'b0, b_i};
    assign lim_w    = a_i[DW-1] ? SMIN : SMAX;
    assign sovf_add = (a_i[DW-1] == b_i[DW-1]) && (sum_w[DW-1] != a_i[DW-1]);
    assign sovf_sub = (a_i[DW-1] != b_i[DW-1]) && (dif_w[DW-1] != a_i[DW-1]);

    always_comb begin
        res_o = '0;
        sat_o = 1'b0;
        unique case (op_i)
            OP_SADD: begin
                sat_o = sovf_add;
                res_o = sovf_add ? lim_w : sum_w[DW-1:0];
            end
            OP_SSUB: begin
                sat_o = sovf_sub;
                res_o = sovf_sub ? lim_w : dif_w[DW-1:0];
            end
            OP_UADD: begin
                sat_o = sum_w[DW];
                res_o = sum_w[DW] ? '1 : sum_w[DW-1:0];
            end
            OP_USUB: begin
                sat_o = dif_w[DW];
                res_o = dif_w[DW] ? '0 : dif_w[DW-1:0];
            end
            OP_SDBL: begin
                if ($signed(a_i) >= $signed(QPOS)) begin
                    sat_o = 1'b1;
                    res_o = SMAX;
                end else if ($signed(a_i) <= $signed(QNEG)) begin
                    sat_o = 1'b1;
                    res_o = SMIN;
                end else begin
                    res_o = {a_i[DW-2:0], 1'b0};
                end
            end
            default: begin
                res_o = '0;
                sat_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W  = 16,
    parameter int DW = 32,
    parameter int PW = 5
) (
    input  logic [W-1:0]  x_i,
    input  logic [PW-1:0] pos_i,
    input  logic          uns_i,
    output logic [W-1:0]  y_o,
    output logic          sat_o
);
    logic signed [DW:0] xe;
    logic signed [DW:0] top;
    logic [DW-1:0]      mask;
    logic               hi_s;
    logic               lo_s;
    logic               hi_u;

    assign xe   = {{(DW+1-W){x_i[W-1]}}, x_i};
    assign top  = xe >>> pos_i;
    assign mask = (DW'(1) << pos_i) - DW'(1);
    assign hi_s = !xe[DW] && (top != '0);
    assign lo_s = xe[DW] && (top != '1);
    assign hi_u = !xe[DW] && (xe > $signed({1'b0, mask}));

    always_comb begin
        y_o   = x_i;
        sat_o = 1'b0;
        if (uns_i) begin
            if (xe[DW]) begin
                y_o   = '0;
                sat_o = 1'b1;
            end else if (hi_u) begin
                y_o   = mask[W-1:0];
                sat_o = 1'b1;
            end
        end else begin
            if (hi_s) begin
                y_o   = mask[W-1:0];
                sat_o = 1'b1;
            end else if (lo_s) begin
                y_o   = ~mask[W-1:0];
                sat_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky
    import satalu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic set_i,
    output logic sticky_o
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (!clear_i && set_i) state_d = FLAG_SET;
            FLAG_SET:   if (clear_i)           state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    assign sticky_o = (state_q == FLAG_SET);
endmodule

// File: rtl/satalu_top.sv
module satalu_top
    import satalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          clear_i,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [4:0]    pos_i,
    output logic [DW-1:0] result_o,
    output logic          sticky_o
);
    localparam int LANES = 2;
    localparam int HW    = DW / LANES;
    localparam int PW    = 5;

    sat_op_e       op;
    logic [DW-1:0] as_res;
    logic          as_sat;
    logic [DW-1:0] wc_res;
    logic          wc_sat;
    logic [DW-1:0] ln_res;
    logic [LANES-1:0] ln_sat;
    logic          uns_sel;
    logic          event_w;

    assign op      = sat_op_e'(op_i);
    assign uns_sel = (op == OP_UCLAMP) || (op == OP_ULANE);

    sat_addsub #(.DW(DW)) u_addsub (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (as_res),
        .sat_o (as_sat)
    );

    sat_clamp #(.W(DW), .DW(DW), .PW(PW)) u_word (
        .x_i   (a_i),
        .pos_i (pos_i),
        .uns_i (uns_sel),
        .y_o   (wc_res),
        .sat_o (wc_sat)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp #(.W(HW), .DW(DW), .PW(PW)) u_lane (
            .x_i   (a_i[g*HW +: HW]),
            .pos_i (pos_i),
            .uns_i (uns_sel),
            .y_o   (ln_res[g*HW +: HW]),
            .sat_o (ln_sat[g])
        );
    end

    always_comb begin
        result_o = '0;
        event_w  = 1'b0;
        unique case (op)
            OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_SDBL: begin
                result_o = as_res;
                event_w  = as_sat;
            end
            OP_SCLAMP, OP_UCLAMP: begin
                result_o = wc_res;
                event_w  = wc_sat;
            end
            OP_SLANE, OP_ULANE: begin
                result_o = ln_res;
                event_w  = |ln_sat;
            end
            default: begin
                result_o = '0;
                event_w  = 1'b0;
            end
        endcase
    end

    sat_sticky u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .set_i    (valid_i && event_w),
        .sticky_o (sticky_o)
    );
endmodule

// File: rtl/satalu_chk.sv
module satalu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic        clear_i,
    input logic [3:0]  op_i,
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic [31:0] result_o,
    input logic        sticky_o
);
    a_r1_pos_add_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 && !a_i[31] && !b_i[31]) |-> !result_o[31]);

    a_r3_uadd_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2) |-> (result_o >= a_i));

    a_r3_usub_not_above: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3) |-> (result_o <= a_i));

    a_r3_uadd_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i && op_i == 4'd2 && (a_i + b_i) < a_i) |=> sticky_o);

    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !clear_i) |=> sticky_o);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !sticky_o);

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clear_i) |=> $stable(sticky_o));

    a_r12_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd8) |-> (result_o == 32'd0));

    a_r12_unused_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd8 && !clear_i) |=> $stable(sticky_o));
endmodule

bind satalu_top satalu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .clear_i  (clear_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .sticky_o (sticky_o)
);

// File: tb/sim_satalu_top.sv
`timescale 1ns/1ps
module sim_satalu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        clear_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [4:0]  pos_i = '0;
    logic [31:0] result_o;
    logic        sticky_o;

    int checks = 0;
    int failures = 0;
    bit exp_sticky = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    satalu_top u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .clear_i(clear_i),
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .pos_i(pos_i),
        .result_o(result_o), .sticky_o(sticky_o)
    );

    function automatic longint ssat_ref(longint v, int s, output bit f);
        longint hi = (longint'(1) << s) - 1;
        longint lo = -(longint'(1) << s);
        f = 1'b0;
        if (v > hi) begin f = 1'b1; return hi; end
        if (v < lo) begin f = 1'b1; return lo; end
        return v;
    endfunction

    function automatic longint usat_ref(longint v, int s, output bit f);
        longint hi = (longint'(1) << s) - 1;
        f = 1'b0;
        if (v < 0)  begin f = 1'b1; return 0; end
        if (v > hi) begin f = 1'b1; return hi; end
        return v;
    endfunction

    function automatic logic [32:0] model(int op, logic [31:0] a, logic [31:0] b, int s);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint t;
        longint lo_v, hi_v, lo_r, hi_r;
        bit f = 1'b0;
        bit f2 = 1'b0;
        logic [31:0] r = '0;
        case (op)
            0, 1: begin
                t = (op == 0) ? sa + sb : sa - sb;
                if (t > 64'sd2147483647)       begin f = 1'b1; r = 32'h7FFFFFFF; end
                else if (t < -64'sd2147483648) begin f = 1'b1; r = 32'h80000000; end
                else r = t[31:0];
            end
            2: begin t = ua + ub; if (t > 64'hFFFFFFFF) begin f = 1'b1; r = '1; end else r = t[31:0]; end
            3: begin if (ub > ua) begin f = 1'b1; r = '0; end else r = 32'(ua - ub); end
            4: begin
                if (sa >= 64'sh40000000)       begin f = 1'b1; r = 32'h7FFFFFFF; end
                else if (sa <= -64'sh40000000) begin f = 1'b1; r = 32'h80000000; end
                else r = 32'(sa * 2);
            end
            5: begin t = ssat_ref(sa, s, f); r = t[31:0]; end
            6: begin t = usat_ref(sa, s, f); r = t[31:0]; end
            7, 8: begin
                lo_v = longint'($signed(a[15:0]));
                hi_v = longint'($signed(a[31:16]));
                if (op == 7) begin lo_r = ssat_ref(lo_v, s, f); hi_r = ssat_ref(hi_v, s, f2); end
                else         begin lo_r = usat_ref(lo_v, s, f); hi_r = usat_ref(hi_v, s, f2); end
                r = {hi_r[15:0], lo_r[15:0]};
                f = f | f2;
            end
            default: begin r = '0; f = 1'b0; end
        endcase
        return {f, r};
    endfunction

    function automatic string tag(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7, 8: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic step(int op, logic [31:0] a, logic [31:0] b, int s, bit v, bit c);
        logic [32:0] m;
        string st;
        @(negedge clk);
        op_i = 4'(op); a_i = a; b_i = b; pos_i = 5'(s); valid_i = v; clear_i = c;
        m = model(op, a, b, s);
        #1;
        checks++;
        if (result_o !== m[31:0]) begin
            failures++;
            $display("FAIL %s result op=%0d a=%h b=%h pos=%0d actual=%h expected=%h",
                     tag(op), op, a, b, s, result_o, m[31:0]);
        end
        st = c ? "R9" : (!v ? "R10" : "R8");
        if (c) exp_sticky = 1'b0;
        else if (v && m[32]) exp_sticky = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (sticky_o !== exp_sticky) begin
            failures++;
            $display("FAIL %s sticky op=%0d a=%h actual=%b expected=%b", st, op, a, sticky_o, exp_sticky);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] vals [14];
        int poss [6];
        int k;
        vals = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h40000000,
                 32'h3FFFFFFF, 32'hC0000000, 32'hC0000001, 32'hBFFFFFFF, 32'h00007FFF,
                 32'h00008000, 32'hFFFF8000, 32'h80007FFF};
        poss = '{0, 1, 7, 15, 16, 31};
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (sticky_o !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset actual=%b expected=0", sticky_o);
        end
        rst_n = 1'b1;

        // R10: saturating operation without valid leaves flag low
        step(0, 32'h7FFFFFFF, 32'h1, 0, 1'b0, 1'b0);
        // R8: saturation with valid sets flag, later benign ops keep it
        step(4, 32'hC0000000, 32'h0, 0, 1'b1, 1'b0);
        step(0, 32'h1, 32'h1, 0, 1'b1, 1'b0);
        // R9: clear and set in the same cycle -> clear wins
        step(0, 32'h7FFFFFFF, 32'h1, 0, 1'b1, 1'b1);
        // R12: unused opcode produces no event
        step(12, 32'hFFFFFFFF, 32'hFFFFFFFF, 31, 1'b1, 1'b0);

        k = 0;
        for (int op = 0; op < 9; op++) begin
            for (int i = 0; i < 14; i++) begin
                for (int j = 0; j < 14; j++) begin
                    step(op, vals[i], vals[j], poss[k % 6], 1'b1, (k % 29) == 0);
                    k++;
                end
            end
        end
        for (int n = 0; n < 2500; n++) begin
            int op = $urandom_range(0, 15);
            int s  = ((n % 5) == 0) ? (((n / 5) % 2 == 0) ? 0 : 31) : $urandom_range(0, 31);
            step(op, $urandom(), $urandom(), s, ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 9) == 0));
        end
        finish_run();
    end
endmodule